// File: doc/BRIEF.md
# Low-Power Burst Packet Sequencer

This block sits beside the normal burst controller of a flyback switching regulator. While load is moderate it passes the normal controller's high-side and low-side gate requests straight through. It watches the normal controller's burst ticks and its pulses-per-burst count. Once the count has reached two and the burst rate stays low for two burst periods in a row, it takes over in a low-power mode.

In low-power mode the block runs its own fixed burst clock, nominally 25 kHz. Each tick of that clock opens a packet. The driver-enable output rises, and a wake-up delay passes so that the gate driver and the controller are ready. Two low-side pulses follow, each started by the zero-crossing (valley) input. Enable drops on the valley after the second pulse, and the block then waits for the next tick. The high-side gate stays off for the whole mode. The width of each pulse comes from a digital on-time value supplied by a voltage-mode loop. That value is clamped to a floor that may lie below the current-sense blanking time. A timeout on the valley input keeps the packet from stalling, and an exit request hands control back to the normal path between packets.

Top module: `lpm_burst_seq`

## Requirements
- R1: A synchronous active-low reset puts the block in normal mode with `lpm_active`, `drv_en`, `gate_lo` and `gate_hi` all low.
- R2: In normal mode (`lpm_active` low), `gate_hi` equals `hs_req` and `gate_lo` equals `ls_req`.
- R3: Low-power mode is entered on a `nrm_tick` only if `nrm_pulses` equals 2 and the tick spacing exceeded `LR_CYC` cycles, both on this tick and on the previous one. Spacing is counted from the previous tick, or from reset. `lpm_active` is high in the cycle after that tick.
- R4: While `lpm_active` is high, `gate_hi` is low whatever `hs_req` does.
- R5: In low-power mode, `drv_en` rises once every `BURST_CYC` cycles. The first rise comes `BURST_CYC` cycles after entry.
- R6: The first low-side pulse of a packet starts more than `WAKE_CYC` cycles after `drv_en` rises. A `zcd` pulse during the wake-up delay is ignored.
- R7: Each packet has exactly two `gate_lo` pulses. Once the wake-up delay has passed, and also after the first pulse, a `zcd` sample starts the next pulse in the following cycle.
- R8: After the second pulse, a `zcd` sample drops `drv_en` in the following cycle.
- R9: Each pulse lasts `TON_MIN` cycles if `ton_req` is below `TON_MIN`, `TON_MAX` cycles if it is above `TON_MAX`, and `ton_req` cycles otherwise. The value is taken when the pulse starts.
- R10: Suppose `zcd` is not seen for `ZC_TO` cycles while the block waits to start a pulse. The pulse then starts anyway. The same wait after the second pulse ends the packet instead.
- R11: An `lpm_exit` request made during a packet takes effect only once `drv_en` is low. Normal mode resumes within two cycles after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nrm_tick | input | 1 | One-cycle pulse at each normal burst start |
| nrm_pulses | input | NW | Pulses per burst used by the normal controller |
| hs_req | input | 1 | High-side request from the normal controller |
| ls_req | input | 1 | Low-side request from the normal controller |
| zcd | input | 1 | Zero-crossing (valley) detect |
| ton_req | input | TW | On-time request from the voltage loop, in cycles |
| lpm_exit | input | 1 | Request to leave low-power mode |
| lpm_active | output | 1 | High while in low-power mode |
| drv_en | output | 1 | Driver enable, high during a packet |
| gate_lo | output | 1 | Low-side gate |
| gate_hi | output | 1 | High-side gate |

## Verification
The hardest condition to reach from the ports is the entry qualifier. It needs two consecutive slow bursts at two pulses each. A slow burst followed by a fast one must reset the count. The stimulus first sends slow ticks with three pulses, then a slow tick followed by a fast tick, and only then the two qualifying ticks. `lpm_active` is checked after each tick. Inside the mode, packets are shaped by `zcd` timing. The cases are an early `zcd` during wake-up, no `zcd` at all (timeout), and an exit request in the middle of a packet. A scoreboard pairs each expected clamped width with each measured pulse.

// File: rtl/lpm_burst_seq.sv
module lpm_burst_seq #(
  parameter int BURST_CYC = 5000,
  parameter int LR_CYC    = 6250,
  parameter int WAKE_CYC  = 250,
  parameter int TON_MIN   = 12,
  parameter int TON_MAX   = 500,
  parameter int ZC_TO     = 1000,
  parameter int TW        = 10,
  parameter int NW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nrm_tick,
  input  logic [NW-1:0] nrm_pulses,
  input  logic          hs_req,
  input  logic          ls_req,
  input  logic          zcd,
  input  logic [TW-1:0] ton_req,
  input  logic          lpm_exit,
  output logic          lpm_active,
  output logic          drv_en,
  output logic          gate_lo,
  output logic          gate_hi
);
  localparam int BW   = $clog2(BURST_CYC + 1);
  localparam int PW   = $clog2(LR_CYC + 1);
  localparam int CMX1 = (WAKE_CYC > TON_MAX) ? WAKE_CYC : TON_MAX;
  localparam int CMAX = (CMX1 > ZC_TO) ? CMX1 : ZC_TO;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [2:0] {S_NRM, S_IDLE, S_WAKE, S_ARM, S_ON, S_TAIL} st_t;

  st_t           st;
  logic [BW-1:0] btmr;
  logic [PW-1:0] pcnt;
  logic [CW-1:0] cnt;
  logic [CW-1:0] tlen;
  logic [CW-1:0] ton_cl;
  logic          qual_prev;
  logic          second;
  logic          exit_p;

  wire tick    = (btmr == BW'(BURST_CYC - 1));
  wire qual    = (pcnt == PW'(LR_CYC)) && (nrm_pulses == NW'(2));
  wire zc_tout = (cnt == CW'(ZC_TO - 1));

  always_comb begin
    if (ton_req < TW'(TON_MIN))      ton_cl = CW'(TON_MIN);
    else if (ton_req > TW'(TON_MAX)) ton_cl = CW'(TON_MAX);
    else                             ton_cl = CW'(ton_req);
  end

  assign lpm_active = (st != S_NRM);
  assign drv_en     = (st == S_WAKE) || (st == S_ARM) || (st == S_ON) || (st == S_TAIL);
  assign gate_lo    = (st == S_NRM) ? ls_req : (st == S_ON);
  assign gate_hi    = (st == S_NRM) && hs_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_NRM;
      btmr      <= '0;
      pcnt      <= '0;
      cnt       <= '0;
      tlen      <= '0;
      qual_prev <= 1'b0;
      second    <= 1'b0;
      exit_p    <= 1'b0;
    end else begin
      if (st == S_NRM || tick) btmr <= '0;
      else                     btmr <= btmr + 1'b1;

      if (st != S_NRM && lpm_exit) exit_p <= 1'b1;

      case (st)
        S_NRM: begin
          exit_p <= 1'b0;
          if (nrm_tick) begin
            pcnt      <= '0;
            qual_prev <= qual;
            if (qual && qual_prev) st <= S_IDLE;
          end else if (pcnt != PW'(LR_CYC)) begin
            pcnt <= pcnt + 1'b1;
          end
        end
        S_IDLE: begin
          if (exit_p || lpm_exit) begin
            st        <= S_NRM;
            pcnt      <= '0;
            qual_prev <= 1'b0;
          end else if (tick) begin
            st     <= S_WAKE;
            cnt    <= '0;
            second <= 1'b0;
          end
        end
        S_WAKE: begin
          if (cnt == CW'(WAKE_CYC - 1)) begin
            st  <= S_ARM;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_ARM: begin
          if (zcd || zc_tout) begin
            st   <= S_ON;
            cnt  <= '0;
            tlen <= ton_cl;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_ON: begin
          if (cnt == tlen - 1'b1) begin
            cnt    <= '0;
            second <= 1'b1;
            st     <= second ? S_TAIL : S_ARM;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_TAIL: begin
          if (zcd || zc_tout) st <= S_IDLE;
          else                cnt <= cnt + 1'b1;
        end
        default: st <= S_NRM;
      endcase
    end
  end
endmodule

module lpm_burst_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic nrm_tick,
  input logic lpm_exit,
  input logic lpm_active,
  input logic drv_en,
  input logic gate_lo,
  input logic gate_hi
);
  logic [2:0] pk_n;
  logic       up;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pk_n <= '0;
      up   <= 1'b0;
    end else begin
      up <= 1'b1;
      if (drv_en && !$past(drv_en)) pk_n <= '0;
      else if (lpm_active && gate_lo && !$past(gate_lo) && pk_n != 3'd7) pk_n <= pk_n + 1'b1;
    end
  end

  a_r4_no_high_side: assert property (@(posedge clk) disable iff (!rst_n)
    lpm_active |-> !gate_hi);
  a_r7_gate_in_packet: assert property (@(posedge clk) disable iff (!rst_n)
    (lpm_active && gate_lo) |-> drv_en);
  a_r7_two_pulses_max: assert property (@(posedge clk) disable iff (!rst_n)
    pk_n <= 3'd2);
  a_r3_entry_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (up && $rose(lpm_active)) |-> $past(nrm_tick));
  a_r11_exit_between_packets: assert property (@(posedge clk) disable iff (!rst_n)
    (up && $fell(lpm_active)) |-> !$past(drv_en));
  a_r6_no_pulse_at_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (up && lpm_active && $rose(drv_en)) |-> !gate_lo);
endmodule

bind lpm_burst_seq lpm_burst_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .nrm_tick(nrm_tick), .lpm_exit(lpm_exit),
  .lpm_active(lpm_active), .drv_en(drv_en), .gate_lo(gate_lo), .gate_hi(gate_hi)
);

// File: tb/lpm_burst_seq_tb_top.sv
module lpm_burst_seq_tb_top;
  localparam int BURST = 200, LR = 100, WAKE = 8, TMIN = 3, TMAX = 40, ZTO = 30;

  logic clk = 0, rst_n = 0, nrm_tick = 0, hs_req = 0, ls_req = 0, zcd = 0, lpm_exit = 0;
  logic [3:0] nrm_pulses = 0;
  logic [7:0] ton_req = 0;
  logic lpm_active, drv_en, gate_lo, gate_hi;

  int total = 0, bad = 0, cyc = 0, hi_bad = 0, wcnt = 0, npk = 0, en_t = -1, last_rise = -1;
  bit done = 0;
  bit p_lo = 0, p_en = 0;
  int exp_q[$];

  always #4 clk = ~clk;

  lpm_burst_seq #(.BURST_CYC(BURST), .LR_CYC(LR), .WAKE_CYC(WAKE), .TON_MIN(TMIN),
                  .TON_MAX(TMAX), .ZC_TO(ZTO), .TW(8), .NW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .nrm_tick(nrm_tick), .nrm_pulses(nrm_pulses),
    .hs_req(hs_req), .ls_req(ls_req), .zcd(zcd), .ton_req(ton_req), .lpm_exit(lpm_exit),
    .lpm_active(lpm_active), .drv_en(drv_en), .gate_lo(gate_lo), .gate_hi(gate_hi));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rst_n && lpm_active) begin
      if (gate_hi) hi_bad++;
      if (drv_en && !p_en) begin
        if (last_rise >= 0) chk(cyc - last_rise == BURST, "R5 burst spacing", cyc - last_rise, BURST);
        last_rise = cyc; en_t = cyc; npk = 0;
      end
      if (gate_lo && !p_lo) begin
        if (npk == 0) chk(cyc - en_t > WAKE, "R6 wake delay", cyc - en_t, WAKE + 1);
        npk++; wcnt = 0;
      end
      if (gate_lo) wcnt++;
      if (!gate_lo && p_lo) begin
        int e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
        chk(wcnt == e, "R9 pulse width", wcnt, e);
      end
      if (!drv_en && p_en) chk(npk == 2, "R7 pulses per packet", npk, 2);
    end else if (rst_n) begin
      last_rise = -1;
    end
    p_lo = gate_lo; p_en = drv_en;
  end

  task automatic tick(input int gap);
    repeat (gap - 1) @(negedge clk);
    nrm_tick = 1;
    @(negedge clk);
    nrm_tick = 0;
  endtask

  task automatic zpulse(input int d);
    repeat (d) @(negedge clk);
    zcd = 1;
    @(negedge clk);
    zcd = 0;
  endtask

  task automatic packet(input int ton, input int expw, input bit use_z, input bit early);
    while (!drv_en) @(negedge clk);
    ton_req = 8'(ton);
    exp_q.push_back(expw);
    exp_q.push_back(expw);
    if (use_z) begin
      if (early) begin
        zpulse(2);
        zpulse(9);
      end else zpulse(12);
      while (gate_lo) @(negedge clk);
      zpulse(5);
      while (!gate_lo) @(negedge clk);
      while (gate_lo) @(negedge clk);
      zpulse(5);
      chk(!drv_en, "R8 enable drops after valley", drv_en, 0);
    end else begin
      while (drv_en) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!lpm_active && !drv_en && !gate_lo && !gate_hi, "R1 reset outputs",
        {lpm_active, drv_en, gate_lo, gate_hi}, 0);
    rst_n = 1;
    hs_req = 1; ls_req = 0;
    @(negedge clk);
    chk(gate_hi == 1 && gate_lo == 0, "R2 passthrough a", {gate_hi, gate_lo}, 2);
    hs_req = 0; ls_req = 1;
    @(negedge clk);
    chk(gate_hi == 0 && gate_lo == 1, "R2 passthrough b", {gate_hi, gate_lo}, 1);
    ls_req = 0;

    nrm_pulses = 3;
    tick(150); tick(150);
    chk(!lpm_active, "R3 no entry with three pulses", lpm_active, 0);
    nrm_pulses = 2;
    tick(150); tick(50);
    chk(!lpm_active, "R3 fast burst breaks run", lpm_active, 0);
    tick(150);
    chk(!lpm_active, "R3 one slow period not enough", lpm_active, 0);
    tick(150);
    chk(lpm_active, "R3 entry after two slow periods", lpm_active, 1);
    hs_req = 1;
    nrm_pulses = 5;
    tick(10);
    chk(lpm_active, "R3 later ticks ignored in mode", lpm_active, 1);

    packet(10, 10, 1, 0);   // R9 mid-range
    packet(1, TMIN, 1, 1);  // R9 floor, R6 early zcd ignored
    packet(200, TMAX, 1, 0);// R9 ceiling
    packet(10, 10, 0, 0);   // R10 timeout path

    // R11 exit mid-packet
    while (!drv_en) @(negedge clk);
    lpm_exit = 1;
    @(negedge clk);
    lpm_exit = 0;
    begin
      bit early_exit;
      early_exit = 0;
      exp_q.push_back(5); exp_q.push_back(5);
      ton_req = 5;
      fork
        begin
          zpulse(11);
          while (gate_lo) @(negedge clk);
          zpulse(5);
          while (!gate_lo) @(negedge clk);
          while (gate_lo) @(negedge clk);
          zpulse(5);
        end
        begin
          while (drv_en) begin
            if (!lpm_active) early_exit = 1;
            @(negedge clk);
          end
        end
      join
      chk(!early_exit, "R11 mode held during packet", early_exit, 0);
    end
    repeat (2) @(negedge clk);
    chk(!lpm_active, "R11 normal mode resumed", lpm_active, 0);
    chk(gate_hi == 1, "R11 R2 high side back to passthrough", gate_hi, 1);
    chk(hi_bad == 0, "R4 high side held off in mode", hi_bad, 0);
    chk(exp_q.size() == 0, "R7 all expected pulses seen", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule